// File: doc/BRIEF.md
# Way-Adaptive Cache Resizing Controller

This controller decides how many ways of a set-associative cache stay powered. It watches the stream of cache hits, each tagged with the LRU-stack position that hit. Position 0 is the most recently used line. It gathers two statistics over a window of hits: how often the MRU position was hit, and how often the least-recently-used position among the active ways was hit. A small share of hits at the bottom of the active stack means the last way adds little, so one way is switched off. A large share means the cache is short of capacity, so one way is switched back on.

Windows are measured in counted hits, not in cycles. A workload that never hits never closes a window and never changes the configuration. The output is an active-way count and a contiguous enable mask that starts at way 0. A one-cycle pulse marks each change. The cache arrays, and the write-back of lines in ways that are switched off, belong to the surrounding cache.

Top module: `way_resize_ctrl`

## Requirements
- R1: After reset, all NUM_WAYS (8) ways are active, the mask is all ones and the change pulse is low.
- R2: A window closes on the clock edge that samples its WINDOW_HITS-th counted hit. Only at that edge can the active count change. With no counted hits the configuration never changes.
- R3: `hit_pos_i` gives the stack position, where 0 is MRU and (active count − 1) is the LRU active way. A hit whose position is at or above the active count is discarded: it does not count toward the window or toward either statistic.
- R4: At window close, if LRU_hits × 1000 < 5 × MRU_hits and at least 3 ways are active, the active count drops by exactly one.
- R5: At window close, if LRU_hits × 1000 > 20 × MRU_hits and fewer than NUM_WAYS ways are active, the active count rises by exactly one.
- R6: At window close, when neither strict inequality holds (equality at either threshold included), the active count is unchanged.
- R7: The active count never goes below 2.
- R8: The way mask has bits 0 through (active count − 1) set and all others clear. Ways are therefore removed from the highest index down and restored upward.
- R9: `resize_pulse_o` is high for exactly the one cycle after the edge that changes the active count, and low otherwise.
- R10: The hit, MRU and LRU counters start from zero in every window. The statistics of a closed window have no effect on the next decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_valid_i | input | 1 | A cache hit occurred this cycle |
| hit_pos_i | input | $clog2(NUM_WAYS) | LRU-stack position of the hit (0 = MRU) |
| active_ways_o | output | $clog2(NUM_WAYS+1) | Number of powered ways |
| way_mask_o | output | NUM_WAYS | Per-way enable, bit i enables way i |
| resize_pulse_o | output | 1 | One-cycle pulse on every change of the mask |

## Verification
The hardest conditions to reach are windows that land exactly on a threshold. Each needs a precise mix of MRU, LRU and middle-position hits that sums to the window length. The bench builds these windows directly, using a reduced window length so that the products meet with equality and then cross by one. Discarded hits are shown by sending out-of-range positions and then checking that the window closes only on the true window-th counted hit. Counter clearing is shown by following a grow window with a shrink window, whose decision would flip if any statistics carried over.

// File: rtl/wayrsz_pkg.sv
package wayrsz_pkg;
  typedef enum logic [1:0] {
    DEC_HOLD   = 2'd0,
    DEC_SHRINK = 2'd1,
    DEC_GROW   = 2'd2
  } resize_dec_e;
endpackage

// File: rtl/wayrsz_window_ctr.sv
module wayrsz_window_ctr #(
  parameter int unsigned WINDOW_HITS = 100000,
  localparam int unsigned CNT_W = $clog2(WINDOW_HITS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  output logic last_o
);
  logic [CNT_W-1:0] cnt_q;

  assign last_o = hit_i && (cnt_q == CNT_W'(WINDOW_HITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (last_o) cnt_q <= '0;
    else if (hit_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_WIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(WINDOW_HITS)); // R2
endmodule

// File: rtl/wayrsz_stat_acc.sv
module wayrsz_stat_acc #(
  parameter int unsigned NUM_WAYS = 8,
  parameter int unsigned CNT_W    = 17,
  localparam int unsigned POS_W = $clog2(NUM_WAYS),
  localparam int unsigned AW    = $clog2(NUM_WAYS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [AW-1:0]    act_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] mru_next_o,
  output logic [CNT_W-1:0] lru_next_o
);
  logic [CNT_W-1:0] mru_q, lru_q;
  logic mru_hit, lru_hit;

  assign mru_hit = hit_i && (pos_i == '0);
  assign lru_hit = hit_i && (AW'(pos_i) == act_i - AW'(1));

  assign mru_next_o = mru_q + CNT_W'(mru_hit);
  assign lru_next_o = lru_q + CNT_W'(lru_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mru_q <= '0;
      lru_q <= '0;
    end else if (clear_i) begin
      mru_q <= '0;
      lru_q <= '0;
    end else begin
      mru_q <= mru_next_o;
      lru_q <= lru_next_o;
    end
  end

  AST_STAT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mru_hit && lru_hit)); // R3
endmodule

// File: rtl/wayrsz_decider.sv
module wayrsz_decider
  import wayrsz_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 8,
  parameter int unsigned MIN_WAYS = 2,
  parameter int unsigned CNT_W    = 17,
  parameter int unsigned SCALE    = 1000,
  parameter int unsigned LO_NUM   = 5,
  parameter int unsigned HI_NUM   = 20,
  localparam int unsigned AW     = $clog2(NUM_WAYS + 1),
  localparam int unsigned PROD_W = CNT_W + 16
) (
  input  logic [CNT_W-1:0] mru_i,
  input  logic [CNT_W-1:0] lru_i,
  input  logic [AW-1:0]    act_i,
  output resize_dec_e      dec_o
);
  logic [PROD_W-1:0] lru_scaled, lo_bound, hi_bound;
  logic below_lo, above_hi, can_shrink, can_grow;

  // cross-multiplied ratio test, no divider
  assign lru_scaled = PROD_W'(lru_i) * PROD_W'(SCALE);
  assign lo_bound   = PROD_W'(mru_i) * PROD_W'(LO_NUM);
  assign hi_bound   = PROD_W'(mru_i) * PROD_W'(HI_NUM);
  assign below_lo   = lru_scaled < lo_bound;
  assign above_hi   = lru_scaled > hi_bound;
  assign can_shrink = act_i > AW'(MIN_WAYS);
  assign can_grow   = act_i < AW'(NUM_WAYS);

  always_comb begin
    dec_o = DEC_HOLD;
    if (below_lo && can_shrink)     dec_o = DEC_SHRINK;
    else if (above_hi && can_grow)  dec_o = DEC_GROW;
  end
endmodule

// File: rtl/wayrsz_mask_gen.sv
module wayrsz_mask_gen #(
  parameter int unsigned NUM_WAYS = 8,
  localparam int unsigned AW = $clog2(NUM_WAYS + 1)
) (
  input  logic [AW-1:0]       act_i,
  output logic [NUM_WAYS-1:0] mask_o
);
  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
    assign mask_o[g] = AW'(g) < act_i;
  end
endmodule

// File: rtl/way_resize_ctrl.sv
module way_resize_ctrl
  import wayrsz_pkg::*;
#(
  parameter int unsigned NUM_WAYS    = 8,
  parameter int unsigned MIN_WAYS    = 2,
  parameter int unsigned WINDOW_HITS = 100000,
  parameter int unsigned SCALE       = 1000,
  parameter int unsigned LO_NUM      = 5,
  parameter int unsigned HI_NUM      = 20,
  localparam int unsigned POS_W = $clog2(NUM_WAYS),
  localparam int unsigned AW    = $clog2(NUM_WAYS + 1),
  localparam int unsigned CNT_W = $clog2(WINDOW_HITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hit_valid_i,
  input  logic [POS_W-1:0]    hit_pos_i,
  output logic [AW-1:0]       active_ways_o,
  output logic [NUM_WAYS-1:0] way_mask_o,
  output logic                resize_pulse_o
);
  logic [AW-1:0]    act_q;
  logic             pulse_q;
  logic             hit_ok, win_end;
  logic [CNT_W-1:0] mru_next, lru_next;
  resize_dec_e      dec;

  // hits outside the active stack are dropped
  assign hit_ok = hit_valid_i && (AW'(hit_pos_i) < act_q);

  wayrsz_window_ctr #(.WINDOW_HITS(WINDOW_HITS)) u_win (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hit_i (hit_ok),
    .last_o(win_end)
  );

  wayrsz_stat_acc #(.NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (hit_ok),
    .pos_i     (hit_pos_i),
    .act_i     (act_q),
    .clear_i   (win_end),
    .mru_next_o(mru_next),
    .lru_next_o(lru_next)
  );

  wayrsz_decider #(
    .NUM_WAYS(NUM_WAYS), .MIN_WAYS(MIN_WAYS), .CNT_W(CNT_W),
    .SCALE(SCALE), .LO_NUM(LO_NUM), .HI_NUM(HI_NUM)
  ) u_dec (
    .mru_i(mru_next),
    .lru_i(lru_next),
    .act_i(act_q),
    .dec_o(dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= AW'(NUM_WAYS);
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= win_end && (dec != DEC_HOLD);
      if (win_end) begin
        case (dec)
          DEC_SHRINK: act_q <= act_q - AW'(1);
          DEC_GROW:   act_q <= act_q + AW'(1);
          default:    act_q <= act_q;
        endcase
      end
    end
  end

  wayrsz_mask_gen #(.NUM_WAYS(NUM_WAYS)) u_mask (
    .act_i (act_q),
    .mask_o(way_mask_o)
  );

  assign active_ways_o  = act_q;
  assign resize_pulse_o = pulse_q;

  AST_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q >= AW'(MIN_WAYS)); // R7
  AST_CEIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q <= AW'(NUM_WAYS)); // R5
  AST_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != $past(act_q)) |->
      (act_q == $past(act_q) + AW'(1) || act_q == $past(act_q) - AW'(1))); // R4
  AST_CHANGE_AT_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != $past(act_q)) |-> $past(win_end)); // R2
  AST_PULSE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resize_pulse_o |-> (act_q != $past(act_q))); // R9
  AST_MASK_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(way_mask_o) == int'(act_q)); // R8
endmodule

// File: tb/tb_way_resize_ctrl.sv
module tb_way_resize_ctrl;
  localparam int K = 400;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hit_valid = 1'b0;
  logic [2:0] hit_pos = '0;
  logic [3:0] act_o;
  logic [7:0] mask_o;
  logic       pulse_o;

  int vecs = 0, fails = 0;
  int m_act = 8, m_cnt = 0, m_mru = 0, m_lru = 0;
  bit m_pulse = 0;

  always #5 clk = ~clk;

  way_resize_ctrl #(.WINDOW_HITS(K)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .hit_valid_i(hit_valid), .hit_pos_i(hit_pos),
    .active_ways_o(act_o), .way_mask_o(mask_o), .resize_pulse_o(pulse_o)
  );

  function automatic logic [7:0] exp_mask(int a);
    return 8'((1 << a) - 1);
  endfunction

  task automatic chk_all(string tag);
    vecs++;
    if (int'(act_o) != m_act || mask_o != exp_mask(m_act) || pulse_o != m_pulse) begin
      fails++;
      $display("FAIL %s: act=%0d mask=%h pulse=%0d expected act=%0d mask=%h pulse=%0d",
               tag, act_o, mask_o, pulse_o, m_act, exp_mask(m_act), m_pulse);
    end
  endtask

  task automatic chk_act(string tag, int exp);
    vecs++;
    if (int'(act_o) != exp) begin
      fails++;
      $display("FAIL %s: act=%0d expected %0d", tag, act_o, exp);
    end
  endtask

  // one cycle: drive, clock, update model, sample 2 ns after the edge
  task automatic step(bit v, int pos, string tag);
    hit_valid = v;
    hit_pos = 3'(pos);
    @(posedge clk);
    m_pulse = 0;
    if (v && pos < m_act) begin
      m_cnt++;
      if (pos == 0) m_mru++;
      if (pos == m_act - 1) m_lru++;
      if (m_cnt == K) begin
        longint l = longint'(m_lru) * 1000;
        if (l < 5 * longint'(m_mru) && m_act >= 3) begin m_act--; m_pulse = 1; end
        else if (l > 20 * longint'(m_mru) && m_act < 8) begin m_act++; m_pulse = 1; end
        m_cnt = 0; m_mru = 0; m_lru = 0;
      end
    end
    #2;
    chk_all(tag);
  endtask

  task automatic feed(int m, int l, int o, string tag);
    for (int i = 0; i < l; i++) step(1, m_act - 1, tag);
    for (int i = 0; i < o; i++) step(1, 1, tag);
    for (int i = 0; i < m; i++) step(1, 0, tag);
  endtask

  initial begin
    #(10 * 190000);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    #23 rst_ni = 1'b1;
    #10;
    chk_all("R1");

    // R2: idle never reconfigures
    for (int i = 0; i < 1000; i++) step(0, 0, "R2");
    chk_act("R2", 8);
    // R2: K-1 hits leave it alone, the K-th closes the window
    feed(398, 1, 0, "R2");
    chk_act("R2", 8);
    step(1, 0, "R2");
    chk_act("R4", 7);

    // R3: out-of-range positions are dropped
    for (int i = 0; i < 300; i++) step(1, 7, "R3");
    feed(399, 0, 0, "R3");
    chk_act("R3", 7);
    step(1, 6, "R3");
    chk_act("R3", 6);

    // R4, R7: shrink down to the floor and stay there
    for (int w = 0; w < 4; w++) feed(399, 1, 0, "R4");
    chk_act("R4", 2);
    feed(399, 1, 0, "R7");
    chk_act("R7", 2);
    feed(K, 0, 0, "R7");
    chk_act("R7", 2);

    // R5: grow back to the ceiling and stay
    for (int w = 0; w < 6; w++) feed(390, 10, 0, "R5");
    chk_act("R5", 8);
    feed(390, 10, 0, "R5");
    chk_act("R5", 8);

    // R6: equality at each threshold holds
    feed(200, 1, 199, "R6");
    chk_act("R6", 8);
    feed(100, 2, 298, "R6");
    chk_act("R6", 8);
    feed(201, 1, 198, "R4");
    chk_act("R4", 7);
    feed(100, 3, 297, "R5");
    chk_act("R5", 8);

    // R10: grow then shrink; carried stats would flip the second decision
    feed(399, 1, 0, "R10");
    feed(399, 1, 0, "R10");
    chk_act("R10", 6);
    feed(390, 10, 0, "R10");
    chk_act("R10", 7);
    feed(399, 1, 0, "R10");
    chk_act("R10", 6);

    // random traffic, per-block bias
    for (int b = 0; b < 20; b++) begin
      int mode = int'($urandom_range(0, 2));
      for (int i = 0; i < 2000; i++) begin
        bit v = ($urandom_range(0, 9) < 6);
        int p;
        case (mode)
          0: p = ($urandom_range(0, 999) < 995) ? 0 : int'($urandom_range(0, 7));
          1: p = int'($urandom_range(0, 7));
          default: p = ($urandom_range(0, 1) == 0) ? 0 : m_act - 1;
        endcase
        step(v, p, "R8/R9 random");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule